// File: doc/BRIEF.md
# Double-Buffered Parallel Converter Code Register

This block is the digital front end of a parallel-input converter. A data word arrives on a parallel bus. It is 16 bits wide by default, and a 14-bit build is set through a parameter. An active-low write strobe captures the word into a staging register. A load strobe then moves the staged word into the code register. That register drives the converter code. Several instances can share one load strobe, so the codes of many converters change on the same clock edge.

The strobes and the data bus are brought into the clock domain through two-flop synchronizers. The staging register and the code register then act on the synchronized levels of write and load, using a four-row truth table. In one row both registers are transparent. When write and load are tied into one low-going pulse, the low phase stages the word and the return to high publishes it. An active-low reset acts at once and is released in step with the clock. It forces both registers to zero scale, or to midscale when a static select pin is high. A one-cycle flag marks every change of the code.

Top module: `dbl_buf_dac_reg`

## Requirements
- R1: Bit i of `data_i` lands in bit i of `code_o`, with the most significant bit at index DATA_W-1. DATA_W is 16 by default and 14 in the narrow build.
- R2: With write low and load low (synchronized), the staging register captures the bus and `code_o` keeps its value.
- R3: With write high and load high, `code_o` takes the value held in the staging register.
- R4: With write low and load high, both registers are transparent, so `code_o` follows `data_i`.
- R5: With write high and load low, neither register changes.
- R6: While `rst_ni` is low with `mid_sel_i` = 0, both registers read 0 without waiting for a clock edge, whatever the strobes do.
- R7: While `rst_ni` is low with `mid_sel_i` = 1, both registers read midscale: only bit DATA_W-1 is set (0x8000 for 16 bits, 0x2000 for 14 bits).
- R8: A tied pulse (write and load low together, then high together) leaves `code_o` unchanged while low. When the pulse ends, `code_o` shows the word that was on the bus during the low phase, even if the bus has changed since.
- R9: `upd_o` is high for exactly the cycles in which `code_o` has just taken a new value, once per change.
- R10: A change of strobes or data reaches `code_o` on the third rising clock edge after it, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| mid_sel_i | input | 1 | Static reset-value select: 0 zero scale, 1 midscale |
| wr_ni | input | 1 | Active-low write strobe (asynchronous level) |
| ld_i | input | 1 | Load strobe (asynchronous level) |
| data_i | input | DATA_W | Parallel data word |
| code_o | output | DATA_W | Converter code from the code register |
| upd_o | output | 1 | One-cycle flag on each change of `code_o` |

## Verification
The checker relies on `mid_sel_i` being static. It may change only just before reset is asserted. It also relies on the strobes and data holding each level for longer than the synchronizer depth, so that write and load, which are synchronized separately, are never seen in a skewed combination. The stimulus changes inputs only on falling clock edges. Each level is held for five cycles, and the tied pulse drives both strobes in the same step. Both widths are driven from one shared stimulus stream, with the data truncated for the narrow build.

// File: rtl/dac_reg_pkg.sv
package dac_reg_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_STAGE = 2'd1,
    OP_PUB   = 2'd2,
    OP_THRU  = 2'd3
  } reg_op_e;
endpackage

// File: rtl/dac_rst_sync.sv
module dac_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= {q[STAGES-2:0], 1'b1};
  end

  assign rst_no = q[STAGES-1];
endmodule

// File: rtl/dac_sync.sv
module dac_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg[s] <= RST_VAL;
        else         stg[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg[s] <= RST_VAL;
        else         stg[s] <= stg[s-1];
      end
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/dac_strobe_dec.sv
module dac_strobe_dec
  import dac_reg_pkg::*;
(
  input  logic    wr_n_i,
  input  logic    ld_i,
  output reg_op_e op_o
);
  always_comb begin
    unique case ({wr_n_i, ld_i})
      2'b00:   op_o = OP_STAGE;
      2'b01:   op_o = OP_THRU;
      2'b11:   op_o = OP_PUB;
      default: op_o = OP_HOLD;
    endcase
  end
endmodule

// File: rtl/dac_reg_pair.sv
module dac_reg_pair
  import dac_reg_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] rst_val_i,
  input  reg_op_e      op_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] stage_o,
  output logic [W-1:0] code_o,
  output logic         upd_o
);
  logic [W-1:0] stage_q, stage_d, code_q, code_d;
  logic         upd_q;

  always_comb begin
    stage_d = stage_q;
    code_d  = code_q;
    unique case (op_i)
      OP_STAGE: stage_d = data_i;
      OP_PUB:   code_d  = stage_q;
      OP_THRU: begin
        stage_d = data_i;
        code_d  = data_i;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= rst_val_i;
      code_q  <= rst_val_i;
      upd_q   <= 1'b0;
    end else begin
      stage_q <= stage_d;
      code_q  <= code_d;
      upd_q   <= (code_d != code_q);
    end
  end

  assign stage_o = stage_q;
  assign code_o  = code_q;
  assign upd_o   = upd_q;
endmodule

// File: rtl/dbl_buf_dac_reg.sv
module dbl_buf_dac_reg
  import dac_reg_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mid_sel_i,
  input  logic              wr_ni,
  input  logic              ld_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] code_o,
  output logic              upd_o
);
  localparam logic [DATA_W-1:0] MID_VAL = DATA_W'(1) << (DATA_W - 1);

  logic              rst_sync_n;
  logic              wr_s, ld_s;
  logic [DATA_W-1:0] data_s, stage_q, rst_val;
  reg_op_e           op;

  assign rst_val = mid_sel_i ? MID_VAL : '0;

  dac_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rst_no(rst_sync_n)
  );

  dac_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_wr_sync (
    .clk_i(clk_i), .rst_ni(rst_sync_n), .d_i(wr_ni), .q_o(wr_s)
  );

  dac_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ld_sync (
    .clk_i(clk_i), .rst_ni(rst_sync_n), .d_i(ld_i), .q_o(ld_s)
  );

  dac_sync #(.W(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_data_sync (
    .clk_i(clk_i), .rst_ni(rst_sync_n), .d_i(data_i), .q_o(data_s)
  );

  dac_strobe_dec u_dec (
    .wr_n_i(wr_s),
    .ld_i  (ld_s),
    .op_o  (op)
  );

  dac_reg_pair #(.W(DATA_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_n),
    .rst_val_i(rst_val),
    .op_i     (op),
    .data_i   (data_s),
    .stage_o  (stage_q),
    .code_o   (code_o),
    .upd_o    (upd_o)
  );
endmodule

// File: rtl/dbl_buf_dac_reg_chk.sv
module dbl_buf_dac_reg_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mid_sel_i,
  input logic              wr_s,
  input logic              ld_s,
  input logic [DATA_W-1:0] data_s,
  input logic [DATA_W-1:0] stage_q,
  input logic [DATA_W-1:0] code_o,
  input logic              upd_o
);
  localparam logic [DATA_W-1:0] MID_VAL = DATA_W'(1) << (DATA_W - 1);

  always @(posedge clk_i) begin
    if (!rst_ni && !mid_sel_i)
      assert_rst_zero_R6: assert (code_o == '0 && stage_q == '0);
    if (!rst_ni && mid_sel_i)
      assert_rst_mid_R7: assert (code_o == MID_VAL && stage_q == MID_VAL);
  end

  assert_stage_keeps_code_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_s && !ld_s) |=> $stable(code_o));

  assert_pub_takes_stage_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_s && ld_s) |=> code_o == $past(stage_q));

  assert_thru_follows_bus_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_s && ld_s) |=> code_o == $past(data_s) && stage_q == $past(data_s));

  assert_hold_all_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_s && !ld_s) |=> $stable(code_o) && $stable(stage_q));

  assert_upd_marks_change_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o == (code_o != $past(code_o)));
endmodule

bind dbl_buf_dac_reg dbl_buf_dac_reg_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .mid_sel_i(mid_sel_i),
  .wr_s     (wr_s),
  .ld_s     (ld_s),
  .data_s   (data_s),
  .stage_q  (stage_q),
  .code_o   (code_o),
  .upd_o    (upd_o)
);

// File: tb/dbl_buf_dac_reg_tb_top.sv
`timescale 1ns/1ps
module dbl_buf_dac_reg_tb_top;
  typedef struct {
    logic [15:0] e16;
    logic [13:0] e14;
    string       req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        mid_sel = 1'b0;
  logic        wr_n = 1'b1;
  logic        ld = 1'b0;
  logic [15:0] data = '0;
  logic [15:0] code16;
  logic [13:0] code14;
  logic        upd16, upd14;

  int total = 0;
  int bad = 0;
  int upd_cnt16 = 0;
  int upd_cnt14 = 0;
  int cycles = 0;
  bit done = 1'b0;
  exp_t sb_q[$];

  always #2.5 clk = ~clk;

  dbl_buf_dac_reg #(.DATA_W(16)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mid_sel_i(mid_sel), .wr_ni(wr_n),
    .ld_i(ld), .data_i(data), .code_o(code16), .upd_o(upd16)
  );

  dbl_buf_dac_reg #(.DATA_W(14)) dut14_i (
    .clk_i(clk), .rst_ni(rst_n), .mid_sel_i(mid_sel), .wr_ni(wr_n),
    .ld_i(ld), .data_i(data[13:0]), .code_o(code14), .upd_o(upd14)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_both(string req, logic [15:0] e16, logic [13:0] e14);
    chk({req, " w16"}, code16, e16);
    chk({req, " w14"}, {2'b00, code14}, {2'b00, e14});
  endtask

  // driver: apply a strobe/data level, let it settle, queue the expectation
  task automatic drive(logic w, logic l, logic [15:0] d,
                       logic [15:0] e16, logic [13:0] e14, string req);
    exp_t it;
    @(negedge clk);
    wr_n = w; ld = l; data = d;
    repeat (5) @(negedge clk);
    it.e16 = e16; it.e14 = e14; it.req = req;
    sb_q.push_back(it);
  endtask

  // monitor: sample just after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (upd16) upd_cnt16++;
      if (upd14) upd_cnt14++;
      while (sb_q.size() > 0) begin
        exp_t it;
        it = sb_q.pop_front();
        chk_both(it.req, it.e16, it.e14);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d cycles expected<=100000", cycles);
      finish_run();
    end
  end

  initial begin
    #1 rst_n = 1'b0;
    #1;
    chk_both("R6 zero-scale reset", 16'h0000, 14'h0000);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_both("R6 zero after release", 16'h0000, 14'h0000);

    drive(1'b0, 1'b0, 16'hA5C3, 16'h0000, 14'h0000, "R2 stage keeps code");
    drive(1'b1, 1'b0, 16'h1234, 16'h0000, 14'h0000, "R5 hold");
    drive(1'b1, 1'b1, 16'hFFFF, 16'hA5C3, 14'h25C3, "R3 publish staged, R1 bit map");
    drive(1'b1, 1'b0, 16'h0F0F, 16'hA5C3, 14'h25C3, "R5 hold after publish");
    drive(1'b1, 1'b1, 16'h0F0F, 16'hA5C3, 14'h25C3, "R5 stage untouched by hold");

    // R10: transparent step, check latency edge by edge
    @(negedge clk);
    wr_n = 1'b0; ld = 1'b1; data = 16'h7E81;
    @(posedge clk); @(posedge clk); #1;
    chk_both("R10 no change at edge 2", 16'hA5C3, 14'h25C3);
    @(posedge clk); #1;
    chk_both("R10 change at edge 3", 16'h7E81, 14'h3E81);
    drive(1'b0, 1'b1, 16'h8001, 16'h8001, 14'h0001, "R4 transparent follows bus");
    drive(1'b1, 1'b0, 16'h4444, 16'h8001, 14'h0001, "R5 hold after transparent");

    // R8: tied pulse, bus changes before the rising edge
    drive(1'b0, 1'b0, 16'hBEEF, 16'h8001, 14'h0001, "R8 tied pulse low phase");
    drive(1'b1, 1'b1, 16'h0000, 16'hBEEF, 14'h3EEF, "R8 tied pulse rise publishes");
    drive(1'b1, 1'b0, 16'h0000, 16'hBEEF, 14'h3EEF, "R8 after pulse");
    @(negedge clk);
    chk("R9 update count w16", 16'(upd_cnt16), 16'd4);
    chk("R9 update count w14", 16'(upd_cnt14), 16'd4);

    // R7: midscale reset, overrides strobes
    @(negedge clk);
    mid_sel = 1'b1;
    #0.5 rst_n = 1'b0;
    #0.5;
    chk_both("R7 midscale reset", 16'h8000, 14'h2000);
    wr_n = 1'b0; ld = 1'b1; data = 16'hFFFF;
    repeat (5) @(negedge clk);
    chk_both("R7 reset overrides strobes", 16'h8000, 14'h2000);
    wr_n = 1'b1; ld = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_both("R7 midscale after release", 16'h8000, 14'h2000);
    drive(1'b1, 1'b1, 16'h0000, 16'h8000, 14'h2000, "R7 stage also midscale");
    repeat (2) @(negedge clk);
    chk("R9 no pulse from reset w16", 16'(upd_cnt16), 16'd4);
    chk("R9 no pulse from reset w14", 16'(upd_cnt14), 16'd4);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule